// File: doc/BRIEF.md
# Clock mode transition controller

This block owns the clock configuration of a processor core. Software presents a complete new configuration word in a single write cycle. The word selects the CPU clock source (main oscillator, sub oscillator, on-chip ring oscillator or PLL) and the divider. It also carries the oscillator enables, the PLL high-frequency flag, the two-wait-state bus setting and the oscillation-stop detection enable. The controller compares the requested configuration with the one in force and stores it only when the change follows a permitted path of the clock-mode graph.

Some writes break a rule. The rules cover ordering preconditions, stabilisation readiness, wait-state interlocks and PLL entry and exit restrictions. A write that breaks a rule is dropped, and a sticky error flag is raised. Stabilisation timing is supplied by external counters as per-source ready inputs. A change that depends on a source that is not ready is refused immediately and is never stalled. The outputs give a mode code, the selected source, the divide ratio, the oscillator and PLL enables, and the stored bits the rest of the chip needs.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset the configuration is divider field 00, divide-by-8 set, drive high, main oscillator running, sub and ring oscillators off, PLL off, one wait state, detection off and no error. The outputs read mode 1, source 0 and ratio 8.
- R2: Mode codes are 0 high-speed, 1 middle-speed, 2 low-speed, 3 low-power (sub clock with the main oscillator stopped), 4 PLL, 5 ring and 6 ring with the main oscillator stopped. Source codes are 0 main, 1 sub, 2 ring and 3 PLL. On the main and ring sources the ratio is 8 when divide-by-8 is set. Otherwise the divider field gives the ratio: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 16. On the sub and PLL sources the ratio is 1.
- R3: A rejected write leaves every stored field and output unchanged and sets the error flag. The flag stays set until a cycle with err_clr high and no rejected write.
- R4: A single write that changes both the divider field and the divide-by-8 bit is rejected.
- R5: PLL mode is entered only from high-speed mode with pll_rdy high. It is left only to high-speed mode.
- R6: A configuration with the PLL on and the high-frequency flag set is accepted only when two wait states are already in force. Dropping back to one wait state is rejected while the PLL is on in the current or the requested configuration.
- R7: Leaving the ring source for the main source is rejected unless divide-by-8 is already set.
- R8: When the stored configuration has the main oscillator stopped and the ring oscillator off, the divide-by-8 and drive-high bits are stored as 1, whatever the write carried.
- R9: While detection is enabled, any write that would change the mode, source or ratio is rejected. A write that leaves all three unchanged, including one that clears detection, is accepted.
- R10: Moving to the sub source requires the sub oscillator to be enabled in the current configuration and sub_rdy high. The sub source may not be selected with the sub oscillator disabled. Moving from the sub source to the main source requires main_rdy high.
- R11: Stopping the main oscillator is accepted only when the requested source is sub or ring. Selecting the ring source requires the ring oscillator enabled in the same write.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Configuration write strobe |
| wr_div_sel | input | 2 | Requested divider field |
| wr_div8 | input | 1 | Requested divide-by-8 bit |
| wr_drive_hi | input | 1 | Requested high drive strength |
| wr_main_stop | input | 1 | Requested main oscillator stop |
| wr_sub_en | input | 1 | Requested sub oscillator enable |
| wr_sub_sel | input | 1 | Requested sub clock as CPU clock |
| wr_ring_en | input | 1 | Requested ring oscillator enable |
| wr_ring_sel | input | 1 | Requested ring clock as CPU clock |
| wr_pll_on | input | 1 | Requested PLL operation |
| wr_pll_fast | input | 1 | Requested PLL output above 16 MHz |
| wr_wait2 | input | 1 | Requested two-wait-state bus setting |
| wr_osd_en | input | 1 | Requested oscillation-stop detection enable |
| err_clr | input | 1 | Clear the sticky error flag |
| main_rdy | input | 1 | Main oscillator stable |
| sub_rdy | input | 1 | Sub oscillator stable |
| pll_rdy | input | 1 | PLL locked and stable |
| mode | output | 3 | Current mode code |
| src | output | 2 | Current source code |
| div_ratio | output | 5 | Current divide ratio |
| div8 | output | 1 | Stored divide-by-8 bit |
| drive_hi | output | 1 | Stored drive-strength bit |
| wait2 | output | 1 | Two-wait-state bus setting in force |
| main_osc_on | output | 1 | Main oscillator enable |
| sub_osc_on | output | 1 | Sub oscillator enable |
| ring_osc_on | output | 1 | Ring oscillator enable |
| pll_on | output | 1 | PLL enable |
| err | output | 1 | Sticky rejected-write flag |

## Verification
Each result of a write or an error clear appears one clock edge after the strobe is sampled, because one register stage lies between the write inputs and every output. The driver applies a write on a falling edge and holds it across one rising edge. It then queues the expected output vector, and the monitor compares that vector on the next falling edge, half a period after the outputs settle. For a rejected write, the expected vector is the previous one with the error bit set. Each rejected path therefore shows at the ports that nothing changed.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

    localparam int DIVSEL_W = 2;
    localparam int DIV_MAX  = 16;
    localparam int RATIO_W  = $clog2(DIV_MAX) + 1;
    localparam int MODE_W   = 3;
    localparam int SRC_W    = 2;
    localparam int N_RULES  = 11;

    typedef enum logic [MODE_W-1:0] {
        M_HIGH   = 3'd0,
        M_MID    = 3'd1,
        M_LOW    = 3'd2,
        M_LOWPWR = 3'd3,
        M_PLL    = 3'd4,
        M_RING   = 3'd5,
        M_RINGLP = 3'd6
    } mode_e;

    typedef enum logic [SRC_W-1:0] {
        S_MAIN = 2'd0,
        S_SUB  = 2'd1,
        S_RING = 2'd2,
        S_PLL  = 2'd3
    } src_e;

    typedef struct packed {
        logic [DIVSEL_W-1:0] div_sel;
        logic                div8;
        logic                drive_hi;
        logic                main_stop;
        logic                sub_en;
        logic                sub_sel;
        logic                ring_en;
        logic                ring_sel;
        logic                pll_on;
        logic                pll_fast;
        logic                wait2;
        logic                osd_en;
    } cfg_t;

    typedef struct packed {
        cfg_t cfg;
        logic err;
    } state_t;

    localparam cfg_t CFG_RESET = '{
        div_sel:   '0,
        div8:      1'b1,
        drive_hi:  1'b1,
        main_stop: 1'b0,
        sub_en:    1'b0,
        sub_sel:   1'b0,
        ring_en:   1'b0,
        ring_sel:  1'b0,
        pll_on:    1'b0,
        pll_fast:  1'b0,
        wait2:     1'b0,
        osd_en:    1'b0
    };

endpackage

// File: rtl/clkmode_decode.sv
module clkmode_decode
    import clkmode_pkg::*;
(
    input  logic [DIVSEL_W-1:0] div_sel,
    input  logic                div8,
    input  logic                main_stop,
    input  logic                sub_sel,
    input  logic                ring_sel,
    input  logic                pll_on,
    output mode_e               mode,
    output src_e                src,
    output logic [RATIO_W-1:0]  ratio
);

    logic [RATIO_W-1:0] base_div;

    // shared divider of the main and ring paths
    always_comb begin
        if (div8) begin
            base_div = RATIO_W'(8);
        end else if (div_sel == '1) begin
            base_div = RATIO_W'(DIV_MAX);
        end else begin
            base_div = RATIO_W'(1) << div_sel;
        end
    end

    // ring has priority over the PLL, the PLL over the sub clock
    always_comb begin
        if (ring_sel) begin
            src   = S_RING;
            mode  = main_stop ? M_RINGLP : M_RING;
            ratio = base_div;
        end else if (pll_on) begin
            src   = S_PLL;
            mode  = M_PLL;
            ratio = RATIO_W'(1);
        end else if (sub_sel) begin
            src   = S_SUB;
            mode  = main_stop ? M_LOWPWR : M_LOW;
            ratio = RATIO_W'(1);
        end else begin
            src   = S_MAIN;
            mode  = (div8 || (div_sel != '0)) ? M_MID : M_HIGH;
            ratio = base_div;
        end
    end

endmodule

// File: rtl/clkmode_rules.sv
module clkmode_rules
    import clkmode_pkg::*;
(
    // configuration in force
    input  logic                c_osd_en,
    input  logic [DIVSEL_W-1:0] c_div_sel,
    input  logic                c_div8,
    input  logic                c_wait2,
    input  logic                c_pll_on,
    input  logic                c_pll_fast,
    input  logic                c_sub_en,
    input  mode_e               c_mode,
    input  src_e                c_src,
    input  logic [RATIO_W-1:0]  c_ratio,
    // requested configuration
    input  logic [DIVSEL_W-1:0] n_div_sel,
    input  logic                n_div8,
    input  logic                n_main_stop,
    input  logic                n_sub_en,
    input  logic                n_sub_sel,
    input  logic                n_ring_en,
    input  logic                n_ring_sel,
    input  logic                n_pll_on,
    input  logic                n_pll_fast,
    input  logic                n_wait2,
    input  mode_e               n_mode,
    input  src_e                n_src,
    input  logic [RATIO_W-1:0]  n_ratio,
    // stabilisation status
    input  logic                main_rdy,
    input  logic                sub_rdy,
    input  logic                pll_rdy,
    output logic                legal
);

    logic [N_RULES-1:0] viol;

    always_comb begin
        // frozen while detection is on
        viol[0]  = c_osd_en &&
                   ({c_mode, c_src, c_ratio} != {n_mode, n_src, n_ratio});
        // divider field before divide-by-8, never both at once
        viol[1]  = (n_div_sel != c_div_sel) && (n_div8 != c_div8);
        // PLL entry only from high-speed and when locked
        viol[2]  = (n_mode == M_PLL) && (c_mode != M_PLL) &&
                   ((c_mode != M_HIGH) || !pll_rdy);
        // PLL exit only to high-speed
        viol[3]  = (c_mode == M_PLL) && (n_mode != M_PLL) && (n_mode != M_HIGH);
        // fast PLL needs two wait states in force already
        viol[4]  = n_pll_on && n_pll_fast && !c_wait2 && !(c_pll_on && c_pll_fast);
        // one wait state only with the PLL off
        viol[5]  = c_wait2 && !n_wait2 && (c_pll_on || n_pll_on);
        // ring back to main needs divide-by-8 set beforehand
        viol[6]  = (c_src == S_RING) && (n_src == S_MAIN) && !c_div8;
        // sub entry needs a running and stable sub oscillator
        viol[7]  = (n_src == S_SUB) && (c_src != S_SUB) && (!c_sub_en || !sub_rdy);
        // selected oscillators must be enabled
        viol[8]  = (n_sub_sel && !n_sub_en) || (n_ring_sel && !n_ring_en);
        // sub back to main after main stabilisation
        viol[9]  = (c_src == S_SUB) && (n_src == S_MAIN) && !main_rdy;
        // main may stop only when it does not clock the CPU
        viol[10] = n_main_stop && !((n_src == S_SUB) || (n_src == S_RING));
        legal    = ~|viol;
    end

endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
    import clkmode_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [DIVSEL_W-1:0] wr_div_sel,
    input  logic                wr_div8,
    input  logic                wr_drive_hi,
    input  logic                wr_main_stop,
    input  logic                wr_sub_en,
    input  logic                wr_sub_sel,
    input  logic                wr_ring_en,
    input  logic                wr_ring_sel,
    input  logic                wr_pll_on,
    input  logic                wr_pll_fast,
    input  logic                wr_wait2,
    input  logic                wr_osd_en,
    input  logic                err_clr,
    input  logic                main_rdy,
    input  logic                sub_rdy,
    input  logic                pll_rdy,
    output logic [MODE_W-1:0]   mode,
    output logic [SRC_W-1:0]    src,
    output logic [RATIO_W-1:0]  div_ratio,
    output logic                div8,
    output logic                drive_hi,
    output logic                wait2,
    output logic                main_osc_on,
    output logic                sub_osc_on,
    output logic                ring_osc_on,
    output logic                pll_on,
    output logic                err
);

    state_t             s_d, s_q;
    cfg_t               cand;
    mode_e              cur_mode, cand_mode;
    src_e               cur_src, cand_src;
    logic [RATIO_W-1:0] cur_ratio, cand_ratio;
    logic               legal;

    // requested word with the forced bits applied
    always_comb begin
        cand = '{
            div_sel:   wr_div_sel,
            div8:      wr_div8,
            drive_hi:  wr_drive_hi,
            main_stop: wr_main_stop,
            sub_en:    wr_sub_en,
            sub_sel:   wr_sub_sel,
            ring_en:   wr_ring_en,
            ring_sel:  wr_ring_sel,
            pll_on:    wr_pll_on,
            pll_fast:  wr_pll_fast,
            wait2:     wr_wait2,
            osd_en:    wr_osd_en
        };
        if (cand.main_stop && !cand.ring_en) begin
            cand.div8     = 1'b1;
            cand.drive_hi = 1'b1;
        end
    end

    clkmode_decode i_dec_cur (
        .div_sel   (s_q.cfg.div_sel),
        .div8      (s_q.cfg.div8),
        .main_stop (s_q.cfg.main_stop),
        .sub_sel   (s_q.cfg.sub_sel),
        .ring_sel  (s_q.cfg.ring_sel),
        .pll_on    (s_q.cfg.pll_on),
        .mode      (cur_mode),
        .src       (cur_src),
        .ratio     (cur_ratio)
    );

    clkmode_decode i_dec_cand (
        .div_sel   (cand.div_sel),
        .div8      (cand.div8),
        .main_stop (cand.main_stop),
        .sub_sel   (cand.sub_sel),
        .ring_sel  (cand.ring_sel),
        .pll_on    (cand.pll_on),
        .mode      (cand_mode),
        .src       (cand_src),
        .ratio     (cand_ratio)
    );

    clkmode_rules i_rules (
        .c_osd_en    (s_q.cfg.osd_en),
        .c_div_sel   (s_q.cfg.div_sel),
        .c_div8      (s_q.cfg.div8),
        .c_wait2     (s_q.cfg.wait2),
        .c_pll_on    (s_q.cfg.pll_on),
        .c_pll_fast  (s_q.cfg.pll_fast),
        .c_sub_en    (s_q.cfg.sub_en),
        .c_mode      (cur_mode),
        .c_src       (cur_src),
        .c_ratio     (cur_ratio),
        .n_div_sel   (cand.div_sel),
        .n_div8      (cand.div8),
        .n_main_stop (cand.main_stop),
        .n_sub_en    (cand.sub_en),
        .n_sub_sel   (cand.sub_sel),
        .n_ring_en   (cand.ring_en),
        .n_ring_sel  (cand.ring_sel),
        .n_pll_on    (cand.pll_on),
        .n_pll_fast  (cand.pll_fast),
        .n_wait2     (cand.wait2),
        .n_mode      (cand_mode),
        .n_src       (cand_src),
        .n_ratio     (cand_ratio),
        .main_rdy    (main_rdy),
        .sub_rdy     (sub_rdy),
        .pll_rdy     (pll_rdy),
        .legal       (legal)
    );

    // next state: a rejection outranks a clear in the same cycle
    always_comb begin
        s_d = s_q;
        if (err_clr) begin
            s_d.err = 1'b0;
        end
        if (wr_en) begin
            if (legal) begin
                s_d.cfg = cand;
            end else begin
                s_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cfg: CFG_RESET, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mode        = cur_mode;
    assign src         = cur_src;
    assign div_ratio   = cur_ratio;
    assign div8        = s_q.cfg.div8;
    assign drive_hi    = s_q.cfg.drive_hi;
    assign wait2       = s_q.cfg.wait2;
    assign main_osc_on = !s_q.cfg.main_stop;
    assign sub_osc_on  = s_q.cfg.sub_en;
    assign ring_osc_on = s_q.cfg.ring_en;
    assign pll_on      = s_q.cfg.pll_on;
    assign err         = s_q.err;

    assert_reject_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !legal) |=> (s_q.cfg == $past(s_q.cfg)));

    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.err && !err_clr) |=> s_q.err);

    assert_pll_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_mode == M_PLL) && ($past(cur_mode) != M_PLL)) |-> ($past(cur_mode) == M_HIGH));

    assert_pll_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cur_mode) == M_PLL) && (cur_mode != M_PLL)) |-> (cur_mode == M_HIGH));

    assert_wait_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.cfg.wait2) |-> !$past(s_q.cfg.pll_on));

    assert_ring_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cur_src) == S_RING) && (cur_src == S_MAIN)) |-> $past(s_q.cfg.div8));

    assert_forced_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cfg.main_stop && !s_q.cfg.ring_en) |-> (s_q.cfg.div8 && s_q.cfg.drive_hi));

    assert_detect_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cfg.osd_en |=> $stable({cur_mode, cur_src, cur_ratio}));

    assert_main_stop_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cfg.main_stop |-> ((cur_src == S_SUB) || (cur_src == S_RING)));

endmodule

// File: tb/test_clkmode_ctrl.sv
`timescale 1ns/100ps
module test_clkmode_ctrl;

    typedef struct packed {
        logic [1:0] sel;
        logic d8, drv, mstop, suben, subsel, ringen, ringsel, pll, fast, w2, osd;
    } w_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_div_sel = '0;
    logic wr_div8 = 1'b0, wr_drive_hi = 1'b0, wr_main_stop = 1'b0, wr_sub_en = 1'b0;
    logic wr_sub_sel = 1'b0, wr_ring_en = 1'b0, wr_ring_sel = 1'b0, wr_pll_on = 1'b0;
    logic wr_pll_fast = 1'b0, wr_wait2 = 1'b0, wr_osd_en = 1'b0, err_clr = 1'b0;
    logic main_rdy = 1'b1, sub_rdy = 1'b0, pll_rdy = 1'b0;
    logic [2:0] mode;
    logic [1:0] src;
    logic [4:0] div_ratio;
    logic div8, drive_hi, wait2, main_osc_on, sub_osc_on, ring_osc_on, pll_on, err;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    w_t cur, w;
    logic [2:0] lm;
    logic [1:0] ls;
    logic [4:0] lr;
    logic exp_err = 1'b0;

    logic [18:0] expq[$];
    string tagq[$];

    always #2.5 clk = ~clk;

    clkmode_ctrl i_clkmode_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_div_sel(wr_div_sel),
        .wr_div8(wr_div8), .wr_drive_hi(wr_drive_hi), .wr_main_stop(wr_main_stop),
        .wr_sub_en(wr_sub_en), .wr_sub_sel(wr_sub_sel), .wr_ring_en(wr_ring_en),
        .wr_ring_sel(wr_ring_sel), .wr_pll_on(wr_pll_on), .wr_pll_fast(wr_pll_fast),
        .wr_wait2(wr_wait2), .wr_osd_en(wr_osd_en), .err_clr(err_clr),
        .main_rdy(main_rdy), .sub_rdy(sub_rdy), .pll_rdy(pll_rdy),
        .mode(mode), .src(src), .div_ratio(div_ratio), .div8(div8),
        .drive_hi(drive_hi), .wait2(wait2), .main_osc_on(main_osc_on),
        .sub_osc_on(sub_osc_on), .ring_osc_on(ring_osc_on), .pll_on(pll_on), .err(err)
    );

    // monitor: compare one queued item per falling edge
    always @(negedge clk) begin
        if (expq.size() > 0) begin
            logic [18:0] e, a;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            a = {mode, src, div_ratio, div8, drive_hi, wait2,
                 main_osc_on, sub_osc_on, ring_osc_on, pll_on, err};
            checks++;
            if (a !== e) begin
                fails++;
                $display("FAIL %s: actual %b expected %b (mode,src,ratio,d8,drv,w2,main,sub,ring,pll,err)",
                         t, a, e);
            end
        end
    end

    task automatic push(input string tag);
        expq.push_back({lm, ls, lr, cur.d8, cur.drv, cur.w2, !cur.mstop,
                        cur.suben, cur.ringen, cur.pll, exp_err});
        tagq.push_back(tag);
    endtask

    task automatic drive(input w_t x);
        wr_div_sel = x.sel;   wr_div8 = x.d8;         wr_drive_hi = x.drv;
        wr_main_stop = x.mstop; wr_sub_en = x.suben;  wr_sub_sel = x.subsel;
        wr_ring_en = x.ringen; wr_ring_sel = x.ringsel; wr_pll_on = x.pll;
        wr_pll_fast = x.fast; wr_wait2 = x.w2;        wr_osd_en = x.osd;
    endtask

    task automatic wr_ok(input w_t x, input logic [2:0] em, input logic [1:0] es,
                         input logic [4:0] er, input string tag);
        @(negedge clk);
        drive(x);
        wr_en = 1'b1;
        @(posedge clk);
        cur = x;
        if (x.mstop && !x.ringen) begin  // R8 forcing
            cur.d8  = 1'b1;
            cur.drv = 1'b1;
        end
        lm = em; ls = es; lr = er;
        push(tag);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_rej(input w_t x, input string tag);
        @(negedge clk);
        drive(x);
        wr_en = 1'b1;
        @(posedge clk);
        exp_err = 1'b1;
        push(tag);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clr();
        @(negedge clk);
        err_clr = 1'b1;
        @(posedge clk);
        exp_err = 1'b0;
        push("R3 clear");
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        cur = '{sel: 2'd0, d8: 1'b1, drv: 1'b1, default: 1'b0};
        lm = 3'd1; ls = 2'd0; lr = 5'd8;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        push("R1 reset");
        @(negedge clk);

        // R4 and R3
        w = cur; w.sel = 2'd1; w.d8 = 1'b0; wr_rej(w, "R4 both divider fields");
        w = cur; w.sel = 2'd1; wr_ok(w, 3'd1, 2'd0, 5'd8, "R3 sticky across accepted write");
        clr();
        // R2 divider decode on main
        w = cur; w.d8 = 1'b0; wr_ok(w, 3'd1, 2'd0, 5'd2, "R2 div 01");
        w.sel = 2'd2; wr_ok(w, 3'd1, 2'd0, 5'd4, "R2 div 10");
        w.sel = 2'd3; wr_ok(w, 3'd1, 2'd0, 5'd16, "R2 div 11");
        w.sel = 2'd0; wr_ok(w, 3'd0, 2'd0, 5'd1, "R2 high-speed");
        // R5 entry
        w = cur; w.pll = 1'b1; wr_rej(w, "R5 PLL not ready");
        clr();
        pll_rdy = 1'b1;
        wr_ok(w, 3'd4, 2'd3, 5'd1, "R5 PLL entry");
        // R6 wait-state interlock
        w = cur; w.fast = 1'b1; wr_rej(w, "R6 fast without wait2");
        clr();
        w = cur; w.w2 = 1'b1; wr_ok(w, 3'd4, 2'd3, 5'd1, "R6 wait2 set");
        w.fast = 1'b1; wr_ok(w, 3'd4, 2'd3, 5'd1, "R6 fast PLL");
        w = cur; w.w2 = 1'b0; wr_rej(w, "R6 wait release with PLL on");
        clr();
        // R5 exit
        w = cur; w.pll = 1'b0; w.fast = 1'b0; w.sel = 2'd1; wr_rej(w, "R5 PLL exit to middle");
        clr();
        w = cur; w.pll = 1'b0; w.fast = 1'b0; wr_ok(w, 3'd0, 2'd0, 5'd1, "R5 PLL exit to high");
        w = cur; w.w2 = 1'b0; wr_ok(w, 3'd0, 2'd0, 5'd1, "R6 wait release PLL off");
        w.sel = 2'd1; wr_ok(w, 3'd1, 2'd0, 5'd2, "R2 middle div 2");
        w = cur; w.pll = 1'b1; wr_rej(w, "R5 PLL entry from middle");
        clr();
        // R7 ring path
        w = cur; w.ringen = 1'b1; wr_ok(w, 3'd1, 2'd0, 5'd2, "R7 ring enable");
        w.ringsel = 1'b1; wr_ok(w, 3'd5, 2'd2, 5'd2, "R7 ring entry");
        w = cur; w.ringsel = 1'b0; wr_rej(w, "R7 ring exit without div8");
        clr();
        w = cur; w.d8 = 1'b1; wr_ok(w, 3'd5, 2'd2, 5'd8, "R2 ring div 8");
        w.ringsel = 1'b0; wr_ok(w, 3'd1, 2'd0, 5'd8, "R7 ring exit with div8");
        // R10 sub path
        w = cur; w.subsel = 1'b1; wr_rej(w, "R10 sub not enabled");
        clr();
        w = cur; w.suben = 1'b1; wr_ok(w, 3'd1, 2'd0, 5'd8, "R10 sub enable");
        w.subsel = 1'b1; wr_rej(w, "R10 sub not ready");
        clr();
        sub_rdy = 1'b1;
        wr_ok(w, 3'd2, 2'd1, 5'd1, "R10 sub entry");
        // R8 forcing
        w = cur; w.ringen = 1'b0; wr_ok(w, 3'd2, 2'd1, 5'd1, "R8 ring off");
        w.d8 = 1'b0; wr_ok(w, 3'd2, 2'd1, 5'd1, "R8 div8 cleared on sub");
        w = cur; w.mstop = 1'b1; w.drv = 1'b0; wr_ok(w, 3'd3, 2'd1, 5'd1, "R8 forced bits");
        // R10 return to main
        main_rdy = 1'b0;
        w = cur; w.mstop = 1'b0; w.subsel = 1'b0; wr_rej(w, "R10 main not ready");
        clr();
        main_rdy = 1'b1;
        wr_ok(w, 3'd1, 2'd0, 5'd8, "R10 return to main");
        // R11
        w = cur; w.mstop = 1'b1; wr_rej(w, "R11 main stop on main");
        clr();
        w = cur; w.ringsel = 1'b1; wr_rej(w, "R11 ring select while off");
        clr();
        // R9 detection freeze
        w = cur; w.osd = 1'b1; wr_ok(w, 3'd1, 2'd0, 5'd8, "R9 detection on");
        w.sel = 2'd3; wr_ok(w, 3'd1, 2'd0, 5'd8, "R9 field change without mode change");
        w = cur; w.d8 = 1'b0; wr_rej(w, "R9 ratio change while detecting");
        clr();
        w = cur; w.osd = 1'b0; wr_ok(w, 3'd1, 2'd0, 5'd8, "R9 detection off");
        w.d8 = 1'b0; wr_ok(w, 3'd1, 2'd0, 5'd16, "R9 ratio change after detection off");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule